// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the 32-bit memory-mapped control register bank of a display controller. Software configures the controller through it: interrupt status and enable, a control word that turns the two panel outputs on and off, a configuration word, screen sizes, graphics-layer placement and fetch parameters, background and transparency colours, and timing words. The bank drives one level-sensitive interrupt line. It also gives a timing generator the two panel enables and the active panel sizes.

Most configuration fields are double-buffered. A bus write lands in a pending copy, and a bus read returns that pending copy. The timing generator only ever sees the active copy. Software commits pending values by setting the go bit of one output in the control word. The LCD go bit loads the LCD size and all shared fields. The digital go bit loads the digital size and all shared fields. Each go bit clears itself after one cycle.

The read port is combinational from `addr_i`. A write is a single-cycle strobe on `wr_i`. A frame-done pulse from the display pipeline raises interrupt status bit 0.

Top module: `disp_reg_bank`

## Requirements
- R1: `irq_o` is 1 in the cycle after a register update exactly when (status AND enable) is nonzero. The enable register at offset 0x010 keeps only bits 15:0 of a write.
- R2: Writing the status register at offset 0x00C clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R3: A one-cycle `frame_done_i` pulse sets status bit 0. If a clear of bit 0 arrives in the same cycle, the set wins.
- R4: The control register at offset 0x014 keeps the write masked with 0x07FF9FFF. Its bit 0 drives `lcd_en_o` and its bit 1 drives `dig_en_o`, both from the following cycle.
- R5: A control write with bit 5 (LCD go) set loads the active LCD size and all shared fields from their pending copies on the next clock edge. Bit 6 (digital go) does the same for the digital size and the shared fields. The other output's size is left unchanged.
- R6: A write to a double-buffered register changes its read-back value but not the active value seen at the outputs, until a go.
- R7: A go bit reads back as 1 for exactly one cycle after the control write, then reads 0. The other control bits keep their value.
- R8: The digital size (0x048) and LCD size (0x04C) registers hold pixels-per-line minus 1 in bits 10:0 and lines-per-panel minus 1 in bits 26:16. Both are read back in that form. The active fields appear on `*_ppl_o` and `*_lpp_o` as the same minus-one values.
- R9: Writing the system configuration register at offset 0x004 with bit 1 set resets every register of the bank to its reset value on that edge, and the register then keeps the write masked with 0x301B. The system status register at offset 0x008 always reads 1.
- R10: Writes are masked as follows: configuration (0x018) 0x3FFF, background colours (0x020, 0x024) and transparency colours (0x028, 0x02C) 24 bits, line number (0x034) 0x7FF, horizontal and vertical timing (0x038, 0x03C) 0x0FF0FF3F, polarity (0x040) 0x3FFFF, divisor (0x044) 0x00FF00FF, graphics position (0x058) 0x07FF07FF.
- R11: The following registers have fixed or reset values:
  - Revision (0x000) reads 0x20, and writes to it are ignored.
  - Capability (0x01C) resets to 0x161 and keeps writes masked with 0x3FF.
  - Line status (0x030) reads 0x7FF.
  - FIFO size (0x068) reads 256.
- R12: Video-plane offsets 0x100 to 0x1FC and all unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| frame_done_i | input | 1 | Frame-done pulse |
| irq_o | output | 1 | Level interrupt |
| lcd_en_o | output | 1 | LCD output enable |
| dig_en_o | output | 1 | Digital output enable |
| lcd_ppl_o | output | 11 | Active LCD pixels per line minus 1 |
| lcd_lpp_o | output | 11 | Active LCD lines per panel minus 1 |
| dig_ppl_o | output | 11 | Active digital pixels per line minus 1 |
| dig_lpp_o | output | 11 | Active digital lines per panel minus 1 |

## Verification
The assertions assume three things about the inputs:
- A write is a single-cycle strobe whose address and data are stable at the sampling edge.
- A soft-reset write is never combined with any other register update.
- `frame_done_i` is a clean synchronous pulse.

The stimulus keeps within these assumptions. It drives every input on the falling clock edge and holds each write for exactly one cycle. It raises `frame_done_i` for one cycle only, and only once in the same cycle as a status clear, so that the set-over-clear priority is exercised on purpose.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int IRQ_W   = 16;
  localparam int SZ_W    = 11;
  localparam int NUM_SHD = 21;

  localparam logic [1:0] LD_ANY = 2'd0;
  localparam logic [1:0] LD_LCD = 2'd1;
  localparam logic [1:0] LD_DIG = 2'd2;

  localparam logic [ADDR_W-1:0] OFF_REV    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_SYSST  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_IRQST  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_IRQEN  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_CAP    = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_LSTAT  = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_ATTR   = 12'h060;
  localparam logic [ADDR_W-1:0] OFF_FIFO   = 12'h068;

  localparam logic [DATA_W-1:0] CTRL_MASK   = 32'h07FF9FFF;
  localparam logic [DATA_W-1:0] IDLE_MASK   = 32'h0000301B;
  localparam logic [DATA_W-1:0] CAP_MASK    = 32'h000003FF;
  localparam logic [DATA_W-1:0] CAP_RST     = 32'h00000161;
  localparam logic [DATA_W-1:0] ATTR_MASK   = 32'h000007FF;
  localparam logic [DATA_W-1:0] REV_VAL     = 32'h00000020;
  localparam logic [DATA_W-1:0] LSTAT_VAL   = 32'h000007FF;
  localparam logic [DATA_W-1:0] FIFO_VAL    = 32'h00000100;

  localparam int CTRL_LCD_EN = 0;
  localparam int CTRL_DIG_EN = 1;
  localparam int CTRL_GO_LCD = 5;
  localparam int CTRL_GO_DIG = 6;
  localparam int SYS_SRST    = 1;

  localparam int SHD_SZDIG = 10;
  localparam int SHD_SZLCD = 11;

  // double-buffered fields: offset, write mask, reset value, which go loads them
  localparam logic [ADDR_W-1:0] SHD_OFF [NUM_SHD] = '{
    12'h018, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h034, 12'h038,
    12'h03C, 12'h040, 12'h044, 12'h048, 12'h04C, 12'h050, 12'h054,
    12'h058, 12'h05C, 12'h064, 12'h06C, 12'h070, 12'h074, 12'h078};
  localparam logic [DATA_W-1:0] SHD_MASK [NUM_SHD] = '{
    32'h00003FFF, 32'h00FFFFFF, 32'h00FFFFFF, 32'h00FFFFFF, 32'h00FFFFFF,
    32'h000007FF, 32'h0FF0FF3F, 32'h0FF0FF3F, 32'h0003FFFF, 32'h00FF00FF,
    32'h07FF07FF, 32'h07FF07FF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h07FF07FF,
    32'h07FF07FF, 32'h01FF01FF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'hFFFFFFFF};
  localparam logic [DATA_W-1:0] SHD_RST [NUM_SHD] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0,
    32'h0};
  localparam logic [1:0] SHD_SEL [NUM_SHD] = '{
    LD_ANY, LD_ANY, LD_ANY, LD_ANY, LD_ANY, LD_ANY, LD_ANY, LD_ANY,
    LD_ANY, LD_ANY, LD_DIG, LD_LCD, LD_ANY, LD_ANY, LD_ANY, LD_ANY,
    LD_ANY, LD_ANY, LD_ANY, LD_ANY, LD_ANY};
endpackage

// File: rtl/disp_shadow_reg.sv
module disp_shadow_reg #(
  parameter int         W    = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [1:0] SEL  = 2'd0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         go_lcd_i,
  input  logic         go_dig_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pend_q, act_q;
  logic         load;

  generate
    if (SEL == 2'd1) begin : g_lcd
      assign load = go_lcd_i;
    end else if (SEL == 2'd2) begin : g_dig
      assign load = go_dig_i;
    end else begin : g_any
      assign load = go_lcd_i | go_dig_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST;
      act_q  <= RST;
    end else if (soft_rst_i) begin
      pend_q <= RST;
      act_q  <= RST;
    end else begin
      if (wr_i) pend_q <= wdata_i & MASK;
      if (load) act_q  <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R6
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !soft_rst_i) |=> $stable(act_q));
  // R5
  act_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !soft_rst_i) |=> (act_q == $past(pend_q)));
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int IRQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             st_wr_i,
  input  logic             en_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic             frame_done_i,
  output logic [IRQ_W-1:0] st_o,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] st_q, en_q, clr_mask, set_mask;

  assign clr_mask = st_wr_i ? wdata_i : '0;
  assign set_mask = {{(IRQ_W-1){1'b0}}, frame_done_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else if (soft_rst_i) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_mask) | set_mask;  // set beats clear
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign irq_o = |(st_q & en_q);

  // R2
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr_i && !soft_rst_i) |=> ((st_q & $past(clr_mask & ~set_mask)) == '0));
  // R3
  frame_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !soft_rst_i) |=> st_q[0]);
endmodule

// File: rtl/disp_reg_bank.sv
module disp_reg_bank
  import disp_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_done_i,
  output logic              irq_o,
  output logic              lcd_en_o,
  output logic              dig_en_o,
  output logic [SZ_W-1:0]   lcd_ppl_o,
  output logic [SZ_W-1:0]   lcd_lpp_o,
  output logic [SZ_W-1:0]   dig_ppl_o,
  output logic [SZ_W-1:0]   dig_lpp_o
);
  logic [DATA_W-1:0] ctrl_q, idle_q, cap_q, attr_q;
  logic [DATA_W-1:0] pend [NUM_SHD];
  logic [DATA_W-1:0] act  [NUM_SHD];
  logic [IRQ_W-1:0]  irq_st, irq_en;
  logic              soft_rst, ctrl_wr, go_lcd, go_dig;

  assign soft_rst = wr_i && addr_i == OFF_SYSCFG && wdata_i[SYS_SRST];
  assign ctrl_wr  = wr_i && addr_i == OFF_CTRL;
  assign go_lcd   = ctrl_q[CTRL_GO_LCD];
  assign go_dig   = ctrl_q[CTRL_GO_DIG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      idle_q <= '0;
      cap_q  <= CAP_RST;
      attr_q <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      idle_q <= wdata_i & IDLE_MASK;
      cap_q  <= CAP_RST;
      attr_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= wdata_i & CTRL_MASK;
      end else begin
        ctrl_q[CTRL_GO_LCD] <= 1'b0;
        ctrl_q[CTRL_GO_DIG] <= 1'b0;
      end
      if (wr_i && addr_i == OFF_SYSCFG) idle_q <= wdata_i & IDLE_MASK;
      if (wr_i && addr_i == OFF_CAP)    cap_q  <= wdata_i & CAP_MASK;
      if (wr_i && addr_i == OFF_ATTR)   attr_q <= wdata_i & ATTR_MASK;
    end
  end

  disp_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst),
    .st_wr_i      (wr_i && addr_i == OFF_IRQST),
    .en_wr_i      (wr_i && addr_i == OFF_IRQEN),
    .wdata_i      (wdata_i[IRQ_W-1:0]),
    .frame_done_i (frame_done_i),
    .st_o         (irq_st),
    .en_o         (irq_en),
    .irq_o        (irq_o)
  );

  for (genvar g = 0; g < NUM_SHD; g++) begin : g_shd
    disp_shadow_reg #(
      .W(DATA_W), .MASK(SHD_MASK[g]), .RST(SHD_RST[g]), .SEL(SHD_SEL[g])
    ) u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_i       (wr_i && addr_i == SHD_OFF[g]),
      .wdata_i    (wdata_i),
      .go_lcd_i   (go_lcd),
      .go_dig_i   (go_dig),
      .pend_o     (pend[g]),
      .act_o      (act[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_REV:    rdata_o = REV_VAL;
      OFF_SYSCFG: rdata_o = idle_q;
      OFF_SYSST:  rdata_o = 32'd1;
      OFF_IRQST:  rdata_o = {{(DATA_W-IRQ_W){1'b0}}, irq_st};
      OFF_IRQEN:  rdata_o = {{(DATA_W-IRQ_W){1'b0}}, irq_en};
      OFF_CTRL:   rdata_o = ctrl_q;
      OFF_CAP:    rdata_o = cap_q;
      OFF_LSTAT:  rdata_o = LSTAT_VAL;
      OFF_ATTR:   rdata_o = attr_q;
      OFF_FIFO:   rdata_o = FIFO_VAL;
      default:    rdata_o = '0;
    endcase
    for (int i = 0; i < NUM_SHD; i++)
      if (addr_i == SHD_OFF[i]) rdata_o = pend[i];
  end

  assign lcd_en_o  = ctrl_q[CTRL_LCD_EN];
  assign dig_en_o  = ctrl_q[CTRL_DIG_EN];
  assign lcd_ppl_o = act[SHD_SZLCD][SZ_W-1:0];
  assign lcd_lpp_o = act[SHD_SZLCD][16+SZ_W-1:16];
  assign dig_ppl_o = act[SHD_SZDIG][SZ_W-1:0];
  assign dig_lpp_o = act[SHD_SZDIG][16+SZ_W-1:16];

  // R4
  ctrl_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (lcd_en_o == $past(wdata_i[CTRL_LCD_EN]) &&
                 dig_en_o == $past(wdata_i[CTRL_DIG_EN])));
  // R7
  go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((go_lcd || go_dig) && !ctrl_wr) |=> (!go_lcd && !go_dig));
  // R9
  soft_rst_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!irq_o && !lcd_en_o && !dig_en_o));
endmodule

// File: tb/tb_disp_reg_bank.sv
module tb_disp_reg_bank;
  import disp_reg_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, frame_done_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic              irq_o, lcd_en_o, dig_en_o;
  logic [SZ_W-1:0]   lcd_ppl_o, lcd_lpp_o, dig_ppl_o, dig_lpp_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  disp_reg_bank dut (.*);

  typedef struct packed {
    logic [7:0]        req;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd10, 12'h018, 32'hFFFFFFFF, 32'h00003FFF},  // R10 config
    '{8'd10, 12'h020, 32'hFFFFFFFF, 32'h00FFFFFF},  // R10 background
    '{8'd10, 12'h02C, 32'h12345678, 32'h00345678},  // R10 transparency
    '{8'd10, 12'h038, 32'hFFFFFFFF, 32'h0FF0FF3F},  // R10 timing h
    '{8'd10, 12'h03C, 32'hA5A5A5A5, 32'h05A0A525},  // R10 timing v
    '{8'd10, 12'h044, 32'hFFFFFFFF, 32'h00FF00FF},  // R10 divisor
    '{8'd10, 12'h040, 32'hFFFFFFFF, 32'h0003FFFF},  // R10 polarity
    '{8'd10, 12'h034, 32'h0000FFFF, 32'h000007FF},  // R10 line number
    '{8'd10, 12'h058, 32'hFFFFFFFF, 32'h07FF07FF},  // R10 position
    '{8'd11, 12'h01C, 32'hFFFFFFFF, 32'h000003FF},  // R11 capability
    '{8'd1,  12'h010, 32'hFFFFFFFF, 32'h0000FFFF},  // R1 enable mask
    '{8'd4,  12'h014, 32'hFFFFFF9C, 32'h07FF9F9C},  // R4 control mask
    '{8'd12, 12'h120, 32'hFFFFFFFF, 32'h00000000},  // R12 video plane
    '{8'd12, 12'h300, 32'hFFFFFFFF, 32'h00000000},  // R12 unmapped
    '{8'd11, 12'h000, 32'h00000000, 32'h00000020},  // R11 revision
    '{8'd11, 12'h068, 32'h00000000, 32'h00000100},  // R11 fifo size
    '{8'd11, 12'h030, 32'h00000000, 32'h000007FF},  // R11 line status
    '{8'd9,  12'h008, 32'h00000000, 32'h00000001},  // R9 sys status
    '{8'd8,  12'h05C, 32'hFFFFFFFF, 32'h07FF07FF}   // R8 gfx size
  };

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse_frame();
    @(negedge clk_i); frame_done_i = 1'b1;
    @(negedge clk_i); frame_done_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    chk("R1 reset irq", {31'd0, irq_o}, 32'd0);
    rd(OFF_CAP, d);       chk("R11 cap reset", d, 32'h161);
    rd(12'h06C, d);       chk("R11 row inc reset", d, 32'd1);
    chk("R8 reset size", {10'd0, lcd_lpp_o, lcd_ppl_o}, 32'd0);

    // register table walk
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, d);
      n_chk++;
      if (d !== VECS[i].exp) begin
        n_fail++;
        $display("FAIL R%0d @0x%03h: actual 0x%08h expected 0x%08h",
                 VECS[i].req, VECS[i].addr, d, VECS[i].exp);
      end
    end
    chk("R12 no side effect", {30'd0, dig_en_o, lcd_en_o}, 32'd0);

    // soft reset
    wr(OFF_SYSCFG, 32'h0000FFFF);
    rd(OFF_SYSCFG, d);   chk("R9 idle mask", d, 32'h301B);
    rd(OFF_CAP, d);      chk("R9 cap restored", d, 32'h161);
    rd(OFF_IRQEN, d);    chk("R9 enable cleared", d, 32'd0);
    rd(12'h018, d);      chk("R9 config cleared", d, 32'd0);

    // shadowed sizes
    wr(12'h048, 32'h00050007);
    wr(12'h04C, 32'hF13FF8EF);
    rd(12'h04C, d);      chk("R8 size readback", d, 32'h013F00EF);
    chk("R6 lcd still old", {21'd0, lcd_ppl_o}, 32'd0);
    wr(OFF_CTRL, 32'h00000021);
    rd(OFF_CTRL, d);     chk("R7 go reads one", d, 32'h21);
    chk("R6 active before load", {21'd0, lcd_ppl_o}, 32'd0);
    @(negedge clk_i);
    rd(OFF_CTRL, d);     chk("R7 go self clear", d, 32'h01);
    chk("R5 lcd ppl", {21'd0, lcd_ppl_o}, 32'h0EF);
    chk("R8 lcd lpp", {21'd0, lcd_lpp_o}, 32'h13F);
    chk("R4 lcd enable", {31'd0, lcd_en_o}, 32'd1);
    chk("R5 dig untouched", {10'd0, dig_lpp_o, dig_ppl_o}, 32'd0);
    wr(OFF_CTRL, 32'h00000042);
    @(negedge clk_i);
    chk("R5 dig loaded", {10'd0, dig_lpp_o, dig_ppl_o}, {10'd0, 11'd5, 11'd7});
    chk("R4 enables swap", {30'd0, dig_en_o, lcd_en_o}, 32'd2);
    chk("R5 lcd kept", {21'd0, lcd_ppl_o}, 32'h0EF);

    // interrupts
    wr(OFF_IRQEN, 32'h00000001);
    pulse_frame();
    chk("R3 frame sets irq", {31'd0, irq_o}, 32'd1);
    rd(OFF_IRQST, d);    chk("R3 status bit0", d, 32'd1);
    wr(OFF_IRQST, 32'h00000000);
    chk("R2 zero write keeps", {31'd0, irq_o}, 32'd1);
    wr(OFF_IRQST, 32'h00000001);
    chk("R2 w1c clears", {31'd0, irq_o}, 32'd0);
    rd(OFF_IRQST, d);    chk("R2 status cleared", d, 32'd0);
    wr(OFF_IRQEN, 32'h00000000);
    pulse_frame();
    chk("R1 masked irq", {31'd0, irq_o}, 32'd0);
    wr(OFF_IRQEN, 32'h00000001);
    chk("R1 enable raises irq", {31'd0, irq_o}, 32'd1);
    // set and clear in the same cycle
    @(negedge clk_i); wr_i = 1'b1; addr_i = OFF_IRQST; wdata_i = 32'h1; frame_done_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; frame_done_i = 1'b0;
    rd(OFF_IRQST, d);    chk("R3 set beats clear", d, 32'd1);

    wr(OFF_SYSCFG, 32'h00000002);
    chk("R9 soft reset irq", {31'd0, irq_o}, 32'd0);
    chk("R9 soft reset size", {21'd0, lcd_ppl_o}, 32'd0);

    done = 1;
    finish_run();
  end
endmodule